// File: doc/BRIEF.md
# Serial Transmit Holding Buffer with Status Flags

This block sits between a bus-facing write port and the bit serializer of a serial port. Data words are written into a two-slot holding queue (slot A, then slot B). The oldest word moves into a shift register that the serializer owns. The block does not shift bits itself. It announces each newly loaded word with a one-cycle load pulse, and it frees the shift register when the serializer reports done. From the state of the slots and the shift register it derives the flags that software polls: an occupancy count, a level flag with a selectable threshold, an idle flag, a sticky overflow flag and, for stereo audio framing, which channel the next word should carry.

A large-frame configuration restricts storage to slot A plus the shift register, so wide frames occupy fewer places. In audio framing mode each written word is tagged left or right. The block counts how many right-channel words are still owed to pair with left words already written, up to two.

Top module: `ser_tx_buffer`

## Requirements
- R1: In normal mode `occ_cnt` equals the number of occupied places among slot A, slot B and the shift register (0 to 3).
- R2: In large-frame mode (`cfg_big`=1) only slot A buffers words, and `occ_cnt` counts slot A and the shift register (0 to 2). A write while slot A stays occupied is an overflow.
- R3: A write that finds no free slot leaves the stored words unchanged and sets `ovf_flag`, which stays 1 until reset.
- R4: With `cfg_lvl_sel`=0, `lvl_flag` is 1 exactly when no slot holds a word. The shift register is not counted.
- R5: With `cfg_lvl_sel`=1 in normal mode, `lvl_flag` is 1 when at most one slot is occupied. In large-frame mode both settings give 1 exactly when slot A is empty.
- R6: After reset `lvl_flag`=1 and `idle_flag`=1. `occ_cnt`, `ser_load`, `exp_right`, `exp_right2` and `ovf_flag` are 0.
- R7: `idle_flag` is 1 exactly when the slots and the shift register are all empty.
- R8: The slot A word enters the shift register at a clock edge where the shift register is empty, or where `ser_done` is 1. In the following cycle `ser_load` is 1 and `ser_data` holds that word. Words leave in write order. `ser_done` with an empty shift register has no effect.
- R9: A write whose cycle also moves a word into the shift register is judged against the slots as they stand after that move. A write to a full queue is therefore accepted when `ser_done` frees a place in the same cycle.
- R10: With `cfg_i2s`=1, each accepted write with `wr_right`=0 (left) raises the owed-right count by one, saturating at 2. Each accepted write with `wr_right`=1 lowers it by one, stopping at 0. `exp_right` is 1 when the count is at least 1, and `exp_right2` is 1 when it is 2. When both are 0, a left word is expected.
- R11: With `cfg_i2s`=0 the owed count is held at 0, and `exp_right` and `exp_right2` are 0 whatever `wr_right` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_big | input | 1 | Large-frame mode: slot A is the only buffer slot |
| cfg_lvl_sel | input | 1 | Level threshold: 0 = empty, 1 = at most half full |
| cfg_i2s | input | 1 | Enables left/right channel tracking |
| wr_en | input | 1 | Write strobe for one word |
| wr_data | input | DATA_W | Word to transmit |
| wr_right | input | 1 | Channel tag of the written word (1 = right) |
| ser_done | input | 1 | Serializer has finished the shift register word |
| ser_load | output | 1 | One-cycle pulse: a new word is in the shift register |
| ser_data | output | DATA_W | Shift register contents |
| occ_cnt | output | 2 | Occupancy count |
| lvl_flag | output | 1 | Level flag |
| idle_flag | output | 1 | Nothing left to transmit |
| exp_right | output | 1 | At least one right word expected |
| exp_right2 | output | 1 | Two right words expected |
| ovf_flag | output | 1 | Sticky dropped-write flag |

## Verification
A write and a move into the shift register can fall in the same cycle. The key case is a write to a full queue in the same cycle that `ser_done` frees slot A. The bench provokes this directly with three places occupied, and again many times under random traffic in which writes and done pulses are drawn independently. A behavioural queue model decides acceptance by shifting first and inserting second. Each cycle the bench compares occupancy, overflow, the load pulse and the data that follows against that model, so a design that tests fullness before the move shows up as a spurious overflow or a missing word.

// File: rtl/txb_pkg.sv
`timescale 1ns/1ps
package txb_pkg;

    typedef enum logic [1:0] {
        OWE_NONE = 2'd0,
        OWE_ONE  = 2'd1,
        OWE_TWO  = 2'd2
    } owe_e;

    typedef struct packed {
        logic slot_a;
        logic slot_b;
        logic shreg;
    } occ_t;

    function automatic logic [1:0] occ_count(occ_t o, logic big);
        logic [1:0] n;
        n = {1'b0, o.slot_a} + {1'b0, o.shreg};
        if (!big) n = n + {1'b0, o.slot_b};
        return n;
    endfunction

    function automatic owe_e owe_step(owe_e cur, logic right);
        owe_e nxt;
        nxt = cur;
        if (right) begin
            case (cur)
                OWE_TWO: nxt = OWE_ONE;
                default: nxt = OWE_NONE;
            endcase
        end else begin
            case (cur)
                OWE_NONE: nxt = OWE_ONE;
                default:  nxt = OWE_TWO;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/txb_queue.sv
`timescale 1ns/1ps
module txb_queue
    import txb_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              big,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ser_done,
    output occ_t              occ,
    output logic [DATA_W-1:0] sr_data,
    output logic              load_pulse,
    output logic              accept,
    output logic              ovf
);

    logic [DATA_W-1:0] a_q, b_q, sr_q;
    logic              a_v, b_v, sr_v;
    logic              load_q, ovf_q;

    logic              adv;
    logic              a_mid_v, b_mid_v;
    logic [DATA_W-1:0] a_mid_d;
    logic              to_a, to_b, drop;

    always_comb begin
        adv     = a_v && (!sr_v || ser_done);
        a_mid_v = adv ? b_v : a_v;
        a_mid_d = adv ? b_q : a_q;
        b_mid_v = adv ? 1'b0 : b_v;
        to_a    = wr_en && !a_mid_v;
        to_b    = wr_en && a_mid_v && !b_mid_v && !big;
        drop    = wr_en && !to_a && !to_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_v    <= 1'b0;
            b_v    <= 1'b0;
            sr_v   <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
            sr_q   <= '0;
            load_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (adv) begin
                sr_v <= 1'b1;
                sr_q <= a_q;
            end else if (ser_done) begin
                sr_v <= 1'b0;
            end
            a_v    <= a_mid_v | to_a;
            a_q    <= to_a ? wr_data : a_mid_d;
            b_v    <= b_mid_v | to_b;
            if (to_b) b_q <= wr_data;
            load_q <= adv;
            if (drop) ovf_q <= 1'b1;
        end
    end

    assign occ        = '{slot_a: a_v, slot_b: b_v, shreg: sr_v};
    assign sr_data    = sr_q;
    assign load_pulse = load_q;
    assign accept     = to_a | to_b;
    assign ovf        = ovf_q;

endmodule

// File: rtl/txb_status.sv
`timescale 1ns/1ps
module txb_status
    import txb_pkg::*;
(
    input  occ_t       occ,
    input  logic       big,
    input  logic       lvl_sel,
    output logic [1:0] cnt,
    output logic       lvl,
    output logic       idle
);

    always_comb begin
        cnt = occ_count(occ, big);
        if (big)          lvl = !occ.slot_a;
        else if (lvl_sel) lvl = !occ.slot_b;
        else              lvl = !(occ.slot_a | occ.slot_b);
        idle = !(occ.slot_a | occ.slot_b | occ.shreg);
    end

endmodule

// File: rtl/txb_chan.sv
`timescale 1ns/1ps
module txb_chan
    import txb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic i2s,
    input  logic accept,
    input  logic right,
    output logic exp1,
    output logic exp2
);

    owe_e owe_q;

    always_ff @(posedge clk) begin
        if (rst || !i2s)  owe_q <= OWE_NONE;
        else if (accept)  owe_q <= owe_step(owe_q, right);
    end

    assign exp1 = i2s && (owe_q != OWE_NONE);
    assign exp2 = i2s && (owe_q == OWE_TWO);

endmodule

// File: rtl/ser_tx_buffer.sv
`timescale 1ns/1ps
module ser_tx_buffer
    import txb_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_big,
    input  logic              cfg_lvl_sel,
    input  logic              cfg_i2s,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_right,
    input  logic              ser_done,
    output logic              ser_load,
    output logic [DATA_W-1:0] ser_data,
    output logic [1:0]        occ_cnt,
    output logic              lvl_flag,
    output logic              idle_flag,
    output logic              exp_right,
    output logic              exp_right2,
    output logic              ovf_flag
);

    occ_t occ;
    logic accept;

    txb_queue #(.DATA_W(DATA_W)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .big        (cfg_big),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ser_done   (ser_done),
        .occ        (occ),
        .sr_data    (ser_data),
        .load_pulse (ser_load),
        .accept     (accept),
        .ovf        (ovf_flag)
    );

    txb_status u_status (
        .occ     (occ),
        .big     (cfg_big),
        .lvl_sel (cfg_lvl_sel),
        .cnt     (occ_cnt),
        .lvl     (lvl_flag),
        .idle    (idle_flag)
    );

    txb_chan u_chan (
        .clk    (clk),
        .rst    (rst),
        .i2s    (cfg_i2s),
        .accept (accept),
        .right  (wr_right),
        .exp1   (exp_right),
        .exp2   (exp_right2)
    );

endmodule

// File: rtl/txb_checker.sv
`timescale 1ns/1ps
module txb_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_big,
    input logic       cfg_lvl_sel,
    input logic       cfg_i2s,
    input logic       ser_load,
    input logic [1:0] occ_cnt,
    input logic       lvl_flag,
    input logic       idle_flag,
    input logic       exp_right,
    input logic       exp_right2,
    input logic       ovf_flag
);

    p_idle_cnt_r7: assert property (@(posedge clk) disable iff (rst)
        !cfg_big |-> (idle_flag == (occ_cnt == 2'd0)));

    p_big_max_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_big |-> (occ_cnt <= 2'd2));

    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    p_reset_vals_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lvl_flag && idle_flag && !ovf_flag && !ser_load && occ_cnt == 2'd0));

    p_load_holds_r8: assert property (@(posedge clk) disable iff (rst)
        ser_load |-> (occ_cnt != 2'd0 && !idle_flag));

    p_lvl_empty_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_lvl_sel && lvl_flag) |-> (occ_cnt <= 2'd1));

    p_lvl_half_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_big && cfg_lvl_sel && occ_cnt == 2'd3) |-> !lvl_flag);

    p_exp_nest_r10: assert property (@(posedge clk) disable iff (rst)
        exp_right2 |-> exp_right);

    p_noi2s_r11: assert property (@(posedge clk) disable iff (rst)
        !cfg_i2s |-> (!exp_right && !exp_right2));

endmodule

bind ser_tx_buffer txb_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_big     (cfg_big),
    .cfg_lvl_sel (cfg_lvl_sel),
    .cfg_i2s     (cfg_i2s),
    .ser_load    (ser_load),
    .occ_cnt     (occ_cnt),
    .lvl_flag    (lvl_flag),
    .idle_flag   (idle_flag),
    .exp_right   (exp_right),
    .exp_right2  (exp_right2),
    .ovf_flag    (ovf_flag)
);

// File: tb/sim_ser_tx_buffer.sv
`timescale 1ns/1ps
module sim_ser_tx_buffer;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_big = 1'b0, cfg_lvl_sel = 1'b0, cfg_i2s = 1'b0;
    logic          wr_en = 1'b0, wr_right = 1'b0, ser_done = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          ser_load, lvl_flag, idle_flag, exp_right, exp_right2, ovf_flag;
    logic [DW-1:0] ser_data;
    logic [1:0]    occ_cnt;

    always #5 clk = ~clk;

    ser_tx_buffer #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .cfg_big(cfg_big), .cfg_lvl_sel(cfg_lvl_sel),
        .cfg_i2s(cfg_i2s), .wr_en(wr_en), .wr_data(wr_data), .wr_right(wr_right),
        .ser_done(ser_done), .ser_load(ser_load), .ser_data(ser_data),
        .occ_cnt(occ_cnt), .lvl_flag(lvl_flag), .idle_flag(idle_flag),
        .exp_right(exp_right), .exp_right2(exp_right2), .ovf_flag(ovf_flag)
    );

    int n_chk = 0, n_bad = 0;
    bit done_rpt = 0;

    // behavioural reference
    int q[$];
    bit m_srv, m_load, m_ovf;
    int m_srd, m_owe;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        q.delete();
        m_srv = 0; m_load = 0; m_ovf = 0; m_srd = 0; m_owe = 0;
    endtask

    task automatic model_step(bit w, int d, bit r, bit dn);
        bit adv;
        int cap;
        adv = (q.size() > 0) && (!m_srv || dn);
        if (adv) begin
            m_srd = q.pop_front();
            m_srv = 1;
        end else if (dn) m_srv = 0;
        m_load = adv;
        cap = cfg_big ? 1 : 2;
        if (w) begin
            if (q.size() < cap) begin
                q.push_back(d);
                if (cfg_i2s) m_owe = r ? ((m_owe > 0) ? m_owe - 1 : 0)
                                       : ((m_owe < 2) ? m_owe + 1 : 2);
            end else m_ovf = 1;
        end
        if (!cfg_i2s) m_owe = 0;
    endtask

    task automatic compare();
        int ecnt, elvl;
        ecnt = (cfg_big ? ((q.size() > 0) ? 1 : 0) : q.size()) + (m_srv ? 1 : 0);
        if (cfg_big || !cfg_lvl_sel) elvl = (q.size() == 0);
        else                         elvl = (q.size() < 2);
        chk(cfg_big ? "R2" : "R1", "occ_cnt", occ_cnt, ecnt);
        chk(cfg_lvl_sel ? "R5" : "R4", "lvl_flag", lvl_flag, elvl);
        chk("R7", "idle_flag", idle_flag, (ecnt == 0 && q.size() == 0) ? 1 : 0);
        chk("R3", "ovf_flag", ovf_flag, m_ovf);
        chk("R8", "ser_load", ser_load, m_load);
        if (m_load) chk("R8", "ser_data", ser_data, m_srd);
        chk(cfg_i2s ? "R10" : "R11", "exp_right", exp_right, m_owe >= 1);
        chk(cfg_i2s ? "R10" : "R11", "exp_right2", exp_right2, m_owe == 2);
    endtask

    task automatic cyc(bit w, int d, bit r, bit dn);
        wr_en = w; wr_data = DW'(d); wr_right = r; ser_done = dn;
        @(posedge clk);
        model_step(w, d, r, dn);
        @(negedge clk);
        wr_en = 0; ser_done = 0;
        compare();
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        model_reset();
        @(negedge clk);
        compare();
    endtask

    task automatic drain();
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        if (!done_rpt) begin
            done_rpt = 1;
            $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        end
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R6: reset values at the ports
        chk("R6", "lvl_flag", lvl_flag, 1);
        chk("R6", "idle_flag", idle_flag, 1);
        chk("R6", "occ_cnt", occ_cnt, 0);
        chk("R6", "ovf_flag", ovf_flag, 0);

        // R1/R4/R5: fill with no done, then overflow (R3)
        cyc(1, 8'h11, 0, 0);
        cyc(1, 8'h22, 0, 0);
        cfg_lvl_sel = 1; #1; compare();
        cyc(1, 8'h33, 0, 0);
        chk("R1", "full count", occ_cnt, 3);
        cyc(1, 8'h44, 0, 0);
        chk("R3", "overflow set", ovf_flag, 1);
        // R9: write to full queue while done frees a place
        cyc(1, 8'h55, 0, 1);
        chk("R9", "accepted with done", occ_cnt, 3);
        // R8: drain and check order; done on empty shift register ignored
        drain();
        cyc(0, 0, 0, 1);
        chk("R8", "done on empty ignored", occ_cnt, 0);
        cfg_lvl_sel = 0;

        // R2: large-frame mode
        do_reset();
        cfg_big = 1;
        cyc(1, 8'hA1, 0, 0);
        cyc(1, 8'hA2, 0, 0);
        chk("R2", "big full count", occ_cnt, 2);
        cyc(1, 8'hA3, 0, 0);
        chk("R2", "big overflow", ovf_flag, 1);
        drain();
        cfg_big = 0;

        // R10/R11: channel tracking
        do_reset();
        cyc(1, 1, 0, 0);
        chk("R11", "tag ignored", exp_right, 0);
        drain();
        cfg_i2s = 1;
        cyc(1, 2, 0, 1); cyc(1, 3, 1, 1); cyc(1, 4, 0, 1); cyc(1, 5, 0, 1);
        chk("R10", "double right", exp_right2, 1);
        cyc(1, 6, 0, 1);
        cyc(1, 7, 1, 1); cyc(1, 8, 1, 1); cyc(1, 9, 1, 1);
        chk("R10", "back to left", exp_right, 0);
        drain();
        cfg_i2s = 0;

        // random traffic across configurations
        for (int seg = 0; seg < 16; seg++) begin
            do_reset();
            cfg_big = seg[0]; cfg_lvl_sel = seg[1]; cfg_i2s = seg[2];
            for (int i = 0; i < 600; i++)
                cyc(($urandom % 3) != 0, $urandom % 256, $urandom % 2, ($urandom % 3) == 0);
            drain();
        end

        if (!done_rpt) begin
            done_rpt = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
        $finish;
    end

endmodule